// File: doc/BRIEF.md
# Shared Physical Register Reference Tracker

This block keeps the books for a pool of physical registers in a renaming stage where more than one logical register may point at the same physical register. On each rename request it either hands out an idle register, the lowest-numbered one in its free bitmap, or it re-uses a physical register that an identity predictor has named as already holding, or about to hold, the same result. A small saturating reference counter per register records how many live mappings point at it. Each mapping kill removes one reference, and the register goes back to the free pool at the clock edge where its count drops to zero.

The block also holds a written flag and a stored copy of the result for every register. The first result written to a register is kept. Any later write to that register is compared with the stored value instead of replacing it. A difference is reported, with the register index, as an identity misprediction so that the surrounding pipeline can repair its dependency graph. Whichever producer of a shared register finishes last performs the comparison, whatever its place in program order. The alias table, the retirement list and recovery itself live outside this block. A synchronous flush returns every counter, flag and the free pool to their reset state.

Top module: `prf_share_tracker`

## Requirements
- R1: After reset every register is free, no register holds a valid result, and successive fresh requests receive indices 0, 1, 2 and so on in ascending order. `kill_err` and `mism_valid` are low.
- R2: A fresh request (`alloc_req`=1, `reuse_req`=0) with at least one free register raises `alloc_ok` in the same cycle, with `alloc_idx` set to the lowest-numbered free register. That register leaves the free pool at the next clock edge.
- R3: A fresh request while no register is free raises `full` and keeps `alloc_ok` low, and the state does not change.
- R4: A re-use request (`alloc_req`=1, `reuse_req`=1) is granted (`alloc_ok`=1, `alloc_idx`=`reuse_idx`) only when the named register's count is between 1 and 2^CNT_W-2. A granted re-use adds one to the count. A re-use of a free register, or of one whose count is at its maximum, is refused with `alloc_ok`=0 and has no effect.
- R5: A kill removes one reference from `kill_idx`. At the edge where the count reaches zero, the register rejoins the free pool and can be granted in the next cycle.
- R6: A kill aimed at a register whose count is already zero raises `kill_err` for one cycle after the edge and changes nothing.
- R7: The first result write to a register stores `wr_data` and marks the register written. A fresh allocation of that register clears the mark.
- R8: A write to a register that is already marked written does not overwrite the stored value. If the value differs, `mism_valid` goes high in the cycle after the write with `mism_idx` equal to `wr_idx`. An equal value raises nothing.
- R9: `flush` returns the block to its reset state at the next edge. Requests, kills and writes in the flush cycle are discarded, and `kill_err` and `mism_valid` are low afterwards.
- R10: A re-use and a kill of the same register in the same cycle leave its count unchanged, so the register is not released.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| flush | input | 1 | Restore reset state at next edge |
| alloc_req | input | 1 | Rename request present |
| reuse_req | input | 1 | Request re-uses `reuse_idx` instead of a fresh register |
| reuse_idx | input | $clog2(NUM_PREGS) | Register named by the identity predictor |
| alloc_ok | output | 1 | Request granted this cycle |
| alloc_idx | output | $clog2(NUM_PREGS) | Granted register index |
| full | output | 1 | Fresh request stalled, free pool empty |
| kill_valid | input | 1 | One mapping of `kill_idx` is killed |
| kill_idx | input | $clog2(NUM_PREGS) | Register losing a mapping |
| kill_err | output | 1 | Previous kill hit a register with zero count |
| wr_valid | input | 1 | Result write present |
| wr_idx | input | $clog2(NUM_PREGS) | Register being written |
| wr_data | input | DATA_W | Result value |
| mism_valid | output | 1 | Previous write disagreed with stored value |
| mism_idx | output | $clog2(NUM_PREGS) | Register with the mismatch |

## Verification
The hardest situation to reach is a register with several live mappings that receives differing results. That needs a fresh grant, at least one granted re-use, and two writes with unequal data, all before kills release the register and a later grant clears its written flag. Directed sequences build this state on one register while neighbours stay mapped. They also push a count to saturation and drain the pool to empty. Seeded random traffic then draws results from a two-value set and aims kills mostly at mapped registers, so shared registers see both agreeing and disagreeing second writes over and over.

// File: rtl/prf_pkg.sv
package prf_pkg;
  typedef enum logic [1:0] {
    REQ_NONE  = 2'd0,
    REQ_FRESH = 2'd1,
    REQ_REUSE = 2'd2
  } alloc_kind_e;
endpackage

// File: rtl/prf_free_list.sv
module prf_free_list #(
  parameter int NUM_PREGS = 16,
  parameter int IDX_W     = $clog2(NUM_PREGS)
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 flush,
  input  logic                 take,
  input  logic [IDX_W-1:0]     take_idx,
  input  logic [NUM_PREGS-1:0] release_vec,
  output logic [NUM_PREGS-1:0] free_vec,
  output logic                 any_free,
  output logic [IDX_W-1:0]     first_free
);
  logic [NUM_PREGS-1:0] free_q, free_d;

  always_comb begin
    first_free = '0;
    for (int i = NUM_PREGS - 1; i >= 0; i--) begin
      if (free_q[i]) first_free = IDX_W'(i);
    end
  end

  assign any_free = |free_q;
  assign free_vec = free_q;

  always_comb begin
    if (flush) begin
      free_d = '1;
    end else begin
      free_d = free_q | release_vec;
      if (take) free_d[take_idx] = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) free_q <= '1;
    else        free_q <= free_d;
  end
endmodule

// File: rtl/prf_ref_counts.sv
module prf_ref_counts #(
  parameter int NUM_PREGS = 16,
  parameter int CNT_W     = 3,
  parameter int IDX_W     = $clog2(NUM_PREGS)
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 flush,
  input  logic                 inc,
  input  logic [IDX_W-1:0]     inc_idx,
  input  logic                 dec,
  input  logic [IDX_W-1:0]     dec_idx,
  output logic [NUM_PREGS-1:0] zero_vec,
  output logic [NUM_PREGS-1:0] max_vec,
  output logic [NUM_PREGS-1:0] release_vec
);
  for (genvar g = 0; g < NUM_PREGS; g++) begin : g_cnt
    logic [CNT_W-1:0] cnt_q, cnt_d;
    logic hit_inc, hit_dec, cnt_en;

    assign hit_inc = inc && (inc_idx == IDX_W'(g));
    assign hit_dec = dec && (dec_idx == IDX_W'(g));
    assign cnt_en  = flush || (hit_inc ^ hit_dec);

    always_comb begin
      cnt_d = cnt_q;
      if (flush)                    cnt_d = '0;
      else if (hit_inc && !hit_dec) cnt_d = cnt_q + 1'b1;
      else if (hit_dec && !hit_inc) cnt_d = cnt_q - 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      cnt_q <= '0;
      else if (cnt_en) cnt_q <= cnt_d;
    end

    assign zero_vec[g]    = (cnt_q == '0);
    assign max_vec[g]     = &cnt_q;
    assign release_vec[g] = !flush && hit_dec && !hit_inc && (cnt_q == CNT_W'(1));
  end
endmodule

// File: rtl/prf_result_check.sv
module prf_result_check #(
  parameter int NUM_PREGS = 16,
  parameter int DATA_W    = 32,
  parameter int IDX_W     = $clog2(NUM_PREGS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              flush,
  input  logic              clr,
  input  logic [IDX_W-1:0]  clr_idx,
  input  logic              wr,
  input  logic [IDX_W-1:0]  wr_idx,
  input  logic [DATA_W-1:0] wr_data,
  output logic              mism_valid,
  output logic [IDX_W-1:0]  mism_idx
);
  logic [NUM_PREGS-1:0] written_q, written_d;
  logic [DATA_W-1:0]    data_q [NUM_PREGS];
  logic                 wr_live, store_en, mism_d, mism_q;
  logic [IDX_W-1:0]     mism_idx_q;

  assign wr_live  = wr && !flush && !(clr && (clr_idx == wr_idx));
  assign store_en = wr_live && !written_q[wr_idx];
  assign mism_d   = wr_live && written_q[wr_idx] && (data_q[wr_idx] != wr_data);

  always_comb begin
    if (flush) begin
      written_d = '0;
    end else begin
      written_d = written_q;
      if (store_en) written_d[wr_idx] = 1'b1;
      if (clr)      written_d[clr_idx] = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) written_q <= '0;
    else        written_q <= written_d;
  end

  always_ff @(posedge clk) begin
    if (store_en) data_q[wr_idx] <= wr_data;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mism_q     <= 1'b0;
      mism_idx_q <= '0;
    end else begin
      mism_q <= mism_d;
      if (wr) mism_idx_q <= wr_idx;
    end
  end

  assign mism_valid = mism_q;
  assign mism_idx   = mism_idx_q;
endmodule

// File: rtl/prf_share_tracker.sv
module prf_share_tracker
  import prf_pkg::*;
#(
  parameter int NUM_PREGS = 16,
  parameter int CNT_W     = 3,
  parameter int DATA_W    = 32,
  parameter int IDX_W     = $clog2(NUM_PREGS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              flush,
  input  logic              alloc_req,
  input  logic              reuse_req,
  input  logic [IDX_W-1:0]  reuse_idx,
  output logic              alloc_ok,
  output logic [IDX_W-1:0]  alloc_idx,
  output logic              full,
  input  logic              kill_valid,
  input  logic [IDX_W-1:0]  kill_idx,
  output logic              kill_err,
  input  logic              wr_valid,
  input  logic [IDX_W-1:0]  wr_idx,
  input  logic [DATA_W-1:0] wr_data,
  output logic              mism_valid,
  output logic [IDX_W-1:0]  mism_idx
);
  logic [1:0]           rst_pipe;
  logic                 rst_n_int;
  alloc_kind_e          kind;
  logic [NUM_PREGS-1:0] free_vec, zero_vec, max_vec, release_vec;
  logic                 any_free, reuse_ok, grant, take, dec, kerr_d, kerr_q;
  logic [IDX_W-1:0]     first_free;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= 2'b00;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_n_int = rst_pipe[1];

  always_comb begin
    if (!alloc_req)     kind = REQ_NONE;
    else if (reuse_req) kind = REQ_REUSE;
    else                kind = REQ_FRESH;
  end

  assign reuse_ok = !zero_vec[reuse_idx] && !max_vec[reuse_idx];

  always_comb begin
    alloc_ok  = 1'b0;
    alloc_idx = '0;
    full      = 1'b0;
    case (kind)
      REQ_FRESH: begin
        alloc_ok  = any_free;
        alloc_idx = first_free;
        full      = !any_free;
      end
      REQ_REUSE: begin
        alloc_ok  = reuse_ok;
        alloc_idx = reuse_idx;
      end
      default: ;
    endcase
  end

  assign grant  = alloc_ok && !flush;
  assign take   = grant && (kind == REQ_FRESH);
  assign dec    = kill_valid && !zero_vec[kill_idx] && !flush;
  assign kerr_d = kill_valid && zero_vec[kill_idx] && !flush;

  always_ff @(posedge clk or negedge rst_n_int) begin
    if (!rst_n_int) kerr_q <= 1'b0;
    else            kerr_q <= kerr_d;
  end
  assign kill_err = kerr_q;

  prf_free_list #(.NUM_PREGS(NUM_PREGS), .IDX_W(IDX_W)) u_free (
    .clk(clk), .rst_n(rst_n_int), .flush(flush),
    .take(take), .take_idx(first_free), .release_vec(release_vec),
    .free_vec(free_vec), .any_free(any_free), .first_free(first_free)
  );

  prf_ref_counts #(.NUM_PREGS(NUM_PREGS), .CNT_W(CNT_W), .IDX_W(IDX_W)) u_cnt (
    .clk(clk), .rst_n(rst_n_int), .flush(flush),
    .inc(grant), .inc_idx(alloc_idx), .dec(dec), .dec_idx(kill_idx),
    .zero_vec(zero_vec), .max_vec(max_vec), .release_vec(release_vec)
  );

  prf_result_check #(.NUM_PREGS(NUM_PREGS), .DATA_W(DATA_W), .IDX_W(IDX_W)) u_chk_data (
    .clk(clk), .rst_n(rst_n_int), .flush(flush),
    .clr(take), .clr_idx(first_free),
    .wr(wr_valid), .wr_idx(wr_idx), .wr_data(wr_data),
    .mism_valid(mism_valid), .mism_idx(mism_idx)
  );
endmodule

// File: rtl/prf_share_tracker_chk.sv
module prf_share_tracker_chk #(
  parameter int NUM_PREGS = 16,
  parameter int IDX_W     = $clog2(NUM_PREGS)
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic                 flush,
  input logic                 alloc_req,
  input logic                 reuse_req,
  input logic [IDX_W-1:0]     reuse_idx,
  input logic                 alloc_ok,
  input logic [IDX_W-1:0]     alloc_idx,
  input logic                 full,
  input logic                 kill_valid,
  input logic                 kill_err,
  input logic                 wr_valid,
  input logic [IDX_W-1:0]     wr_idx,
  input logic                 mism_valid,
  input logic [IDX_W-1:0]     mism_idx,
  input logic [NUM_PREGS-1:0] free_vec
);
  // R3: a stalled fresh request is never granted
  a_r3_full_blocks_grant: assert property (@(posedge clk) disable iff (!rst_n)
    full |-> !alloc_ok);

  // R2: a granted fresh register is out of the free pool after the edge
  a_r2_grant_leaves_pool: assert property (@(posedge clk) disable iff (!rst_n)
    (alloc_req && !reuse_req && alloc_ok && !flush) |=> !free_vec[$past(alloc_idx)]);

  // R4: re-use of a free register is refused
  a_r4_reuse_free_refused: assert property (@(posedge clk) disable iff (!rst_n)
    (alloc_req && reuse_req && free_vec[reuse_idx]) |-> !alloc_ok);

  // R6: a kill error follows a kill outside a flush
  a_r6_kerr_follows_kill: assert property (@(posedge clk) disable iff (!rst_n)
    kill_err |-> ($past(kill_valid) && !$past(flush)));

  // R8: a mismatch follows a write to the reported register
  a_r8_mism_follows_write: assert property (@(posedge clk) disable iff (!rst_n)
    mism_valid |-> ($past(wr_valid) && ($past(wr_idx) == mism_idx) && !$past(flush)));

  // R9: nothing is reported right after a flush
  a_r9_flush_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    $past(flush) |-> (!mism_valid && !kill_err));
endmodule

bind prf_share_tracker prf_share_tracker_chk #(.NUM_PREGS(NUM_PREGS), .IDX_W(IDX_W)) u_sva (
  .clk(clk), .rst_n(rst_n), .flush(flush),
  .alloc_req(alloc_req), .reuse_req(reuse_req), .reuse_idx(reuse_idx),
  .alloc_ok(alloc_ok), .alloc_idx(alloc_idx), .full(full),
  .kill_valid(kill_valid), .kill_err(kill_err),
  .wr_valid(wr_valid), .wr_idx(wr_idx),
  .mism_valid(mism_valid), .mism_idx(mism_idx), .free_vec(free_vec)
);

// File: tb/prf_share_tracker_tb.sv
`timescale 1ns/1ps
module prf_share_tracker_tb;
  localparam int NP   = 16;
  localparam int CW   = 3;
  localparam int DW   = 32;
  localparam int IW   = $clog2(NP);
  localparam int MAXC = (1 << CW) - 1;

  logic clk, rst_n, flush;
  logic alloc_req, reuse_req, alloc_ok, full, kill_valid, kill_err, wr_valid, mism_valid;
  logic [IW-1:0] reuse_idx, alloc_idx, kill_idx, wr_idx, mism_idx;
  logic [DW-1:0] wr_data;

  int n_chk = 0;
  int n_fail = 0;
  int m_cnt [NP];
  bit m_wr  [NP];
  logic [DW-1:0] m_dat [NP];

  prf_share_tracker #(.NUM_PREGS(NP), .CNT_W(CW), .DATA_W(DW)) u_dut (
    .clk(clk), .rst_n(rst_n), .flush(flush),
    .alloc_req(alloc_req), .reuse_req(reuse_req), .reuse_idx(reuse_idx),
    .alloc_ok(alloc_ok), .alloc_idx(alloc_idx), .full(full),
    .kill_valid(kill_valid), .kill_idx(kill_idx), .kill_err(kill_err),
    .wr_valid(wr_valid), .wr_idx(wr_idx), .wr_data(wr_data),
    .mism_valid(mism_valid), .mism_idx(mism_idx)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  function automatic int lowest_free();
    for (int i = 0; i < NP; i++) if (m_cnt[i] == 0) return i;
    return -1;
  endfunction

  function automatic int pick_mapped(input int start);
    for (int i = 0; i < NP; i++) if (m_cnt[(start + i) % NP] != 0) return (start + i) % NP;
    return start % NP;
  endfunction

  task automatic model_reset();
    for (int i = 0; i < NP; i++) begin
      m_cnt[i] = 0;
      m_wr[i]  = 1'b0;
    end
  endtask

  task automatic cycle(input bit a, input bit r, input int ridx, input bit kv, input int kidx,
                       input bit wv, input int widx, input logic [DW-1:0] wd, input bit fl,
                       input string lab);
    int lf, kc;
    bit e_ok, e_full, e_kerr, e_mism, fresh;
    int e_idx;
    string la, lk, lm;
    @(negedge clk);
    alloc_req = a; reuse_req = r; reuse_idx = IW'(ridx);
    kill_valid = kv; kill_idx = IW'(kidx);
    wr_valid = wv; wr_idx = IW'(widx); wr_data = wd; flush = fl;
    #1;
    lf = lowest_free();
    fresh = a && !r;
    e_ok = 0; e_full = 0; e_idx = 0;
    if (fresh) begin
      e_ok = (lf >= 0); e_full = (lf < 0); e_idx = lf;
      la = e_full ? "R3" : "R2";
    end else if (a) begin
      e_ok = (m_cnt[ridx] != 0) && (m_cnt[ridx] != MAXC); e_idx = ridx;
      la = "R4";
    end else la = "R2";
    lk = "R6"; lm = "R8";
    if (lab != "") begin la = lab; lk = lab; lm = lab; end
    chk(alloc_ok == e_ok, la, "alloc_ok", int'(alloc_ok), int'(e_ok));
    chk(full == e_full, la, "full", int'(full), int'(e_full));
    if (e_ok) chk(int'(alloc_idx) == e_idx, la, "alloc_idx", int'(alloc_idx), e_idx);
    e_kerr = 0; e_mism = 0;
    if (fl) begin
      model_reset();
    end else begin
      kc = m_cnt[kidx];
      e_kerr = kv && (kc == 0);
      if (wv && !(e_ok && fresh && widx == lf)) begin
        if (m_wr[widx]) e_mism = (m_dat[widx] != wd);
        else begin m_wr[widx] = 1'b1; m_dat[widx] = wd; end
      end
      if (e_ok) begin
        if (fresh) begin m_cnt[lf]++; m_wr[lf] = 1'b0; end
        else m_cnt[ridx]++;
      end
      if (kv && kc != 0) m_cnt[kidx]--;
    end
    @(posedge clk);
    #1;
    chk(kill_err == e_kerr, lk, "kill_err", int'(kill_err), int'(e_kerr));
    chk(mism_valid == e_mism, lm, "mism_valid", int'(mism_valid), int'(e_mism));
    if (e_mism) chk(int'(mism_idx) == widx, lm, "mism_idx", int'(mism_idx), widx);
  endtask

  initial begin
    #(5.0 * 200000);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual 1 expected 0");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    void'($urandom(32'd4242));
    rst_n = 1'b0; flush = 1'b0; alloc_req = 1'b0; reuse_req = 1'b0; reuse_idx = '0;
    kill_valid = 1'b0; kill_idx = '0; wr_valid = 1'b0; wr_idx = '0; wr_data = '0;
    model_reset();
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    repeat (4) @(posedge clk);
    // R1: reset state and ascending fresh grants
    chk(kill_err == 1'b0 && mism_valid == 1'b0, "R1", "events after reset", int'(kill_err | mism_valid), 0);
    cycle(1,0,0, 0,0, 0,0,0, 0, "R1");
    cycle(1,0,0, 0,0, 0,0,0, 0, "R1");
    cycle(1,0,0, 0,0, 0,0,0, 0, "R1");
    // R4: share register 1
    cycle(1,1,1, 0,0, 0,0,0, 0, "R4");
    // R7 / R8: first write stores, equal second passes, different flags, no overwrite
    cycle(0,0,0, 0,0, 1,1,32'd5, 0, "R7");
    cycle(0,0,0, 0,0, 1,1,32'd5, 0, "R8");
    cycle(0,0,0, 0,0, 1,1,32'd9, 0, "R8");
    cycle(0,0,0, 0,0, 1,1,32'd5, 0, "R8");
    // R4: re-use of an unmapped register refused
    cycle(1,1,7, 0,0, 0,0,0, 0, "R4");
    // R6: kill of a register with zero count
    cycle(0,0,0, 1,9, 0,0,0, 0, "R6");
    // R10: reuse and kill of the same register together keep count at 2
    cycle(1,1,1, 1,1, 0,0,0, 0, "R10");
    cycle(0,0,0, 1,1, 0,0,0, 0, "R10");
    cycle(1,0,0, 1,1, 0,0,0, 0, "R10"); // kill reaches zero; fresh here gets 3
    // R5: freed register 1 is granted next
    cycle(1,0,0, 0,0, 0,0,0, 0, "R5");
    // R7: new owner's flag cleared, first write stores 7, then 8 mismatches
    cycle(0,0,0, 0,0, 1,1,32'd7, 0, "R7");
    cycle(0,0,0, 0,0, 1,1,32'd8, 0, "R7");
    // R4: saturate count of register 2
    for (int i = 0; i < MAXC; i++) cycle(1,1,2, 0,0, 0,0,0, 0, "R4");
    // R3: drain the pool
    for (int i = 0; i < NP; i++) cycle(1,0,0, 0,0, 0,0,0, 0, "");
    cycle(1,0,0, 0,0, 0,0,0, 0, "R3");
    // R9: flush with requests pending, then ascending grants again
    cycle(1,0,0, 1,4, 1,5,32'd1, 1, "R9");
    cycle(1,0,0, 0,0, 0,0,0, 0, "R9");
    cycle(0,0,0, 1,3, 1,0,32'd3, 0, "R9");
    // random traffic
    for (int t = 0; t < 4000; t++) begin
      bit a, r, kv, wv, fl;
      int ri, ki, wi;
      a  = ($urandom % 3) != 0;
      r  = a && ($urandom % 2);
      ri = ($urandom % 4 == 0) ? int'($urandom % NP) : pick_mapped(int'($urandom % NP));
      kv = ($urandom % 5) < 2;
      ki = ($urandom % 8 == 0) ? int'($urandom % NP) : pick_mapped(int'($urandom % NP));
      wv = $urandom % 2;
      wi = ($urandom % 4 == 0) ? int'($urandom % NP) : pick_mapped(int'($urandom % NP));
      fl = ($urandom % 300) == 0;
      cycle(a, r, ri, kv, ki, wv, wi, DW'($urandom % 2), fl, "");
    end
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule